// File: doc/BRIEF.md
# Interconnect Transaction Integrity Checker

This block sits beside an interconnect and compares what a master asked for with what the interconnect actually delivered to the slave side. The upstream port reports each request the master issues: its direction, whether it is a burst, and which slave it addresses. These requests wait in a small in-order queue. The downstream port reports each transaction the interconnect emits. On every downstream transaction the oldest waiting request is removed and checked against it, one attribute at a time.

Each kind of mismatch has its own sticky bit in a three-bit status word. Software clears a bit by writing 1 to it through a clear strobe and mask. A separate one-cycle error pulse goes to the system error collector on each faulty transaction, whether or not the matching sticky bit is already set. A downstream transaction that arrives with nothing waiting counts as a destination error, because the interconnect produced traffic that no master asked for.

Top module: `xact_integrity_chk`

## Requirements
- R1: After reset `status` is 0, `err_pulse` is 0 and no request is waiting.
- R2: When the oldest waiting request's `req_write` differs from `dn_write`, `status[0]` is set in the cycle after the downstream transaction.
- R3: When the oldest waiting request's `req_burst` differs from `dn_burst`, `status[1]` is set in the cycle after the downstream transaction.
- R4: When the oldest waiting request's slave index differs from `dn_slave`, or when `dn_valid` is seen with no waiting request, `status[2]` is set in the cycle after. With no waiting request, bits 0 and 1 are left alone.
- R5: A downstream transaction that matches in all three attributes leaves `status` unchanged and raises no `err_pulse`.
- R6: Waiting requests are compared in the order they were issued. Up to DEPTH (4) can wait at once.
- R7: A request that arrives while DEPTH requests are waiting and no downstream transaction occurs in the same cycle is discarded. A request that arrives together with a downstream transaction on a full queue is kept.
- R8: The status bits are sticky. In a cycle with `clr_en` high, each status bit whose `clr_mask` bit is 1 reads 0 in the next cycle, and the bits whose mask bit is 0 keep their value.
- R9: When a mismatch and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `err_pulse` is high for exactly the one cycle after each mismatching downstream transaction, even when the bit it concerns is already set. With `dn_valid` low, `err_pulse` is low in the next cycle.
- R11: A waiting request is consumed only in a cycle with `dn_valid` high. A request issued in the same cycle as a downstream transaction is queued behind it and is not compared with that transaction.
- R12: A single downstream transaction that differs in several attributes sets every matching status bit at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Upstream request present this cycle |
| req_write | input | 1 | Request direction, 1 = write |
| req_burst | input | 1 | Request is a burst |
| req_slave | input | SLV_W | Slave index the request addresses |
| dn_valid | input | 1 | Downstream transaction present this cycle |
| dn_write | input | 1 | Downstream direction, 1 = write |
| dn_burst | input | 1 | Downstream transaction is a burst |
| dn_slave | input | SLV_W | Slave the interconnect selected |
| clr_en | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Write-1-to-clear mask for status bits |
| status | output | 3 | Sticky flags: bit 0 direction, bit 1 burst, bit 2 destination |
| err_pulse | output | 1 | One-cycle pulse to the error collector |

## Verification
Two things can land on the same status bit in one cycle: a software clear and a new mismatch. The bench provokes this by driving `clr_en` with a mask over a bit while a faulty or unexpected downstream transaction arrives, and it expects the bit to stay set and the pulse to fire (R9). A push and a pop can also fall in the same cycle. This is provoked on an empty queue, where the new request must not be compared with the transaction beside it, and on a full queue, where the new request must be kept. A scoreboard model of the queue and status word judges both cases.

// File: rtl/xact_integrity_chk.sv
module xact_integrity_chk #(
  parameter int SLV_W = 2,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_burst,
  input  logic [SLV_W-1:0] req_slave,
  input  logic             dn_valid,
  input  logic             dn_write,
  input  logic             dn_burst,
  input  logic [SLV_W-1:0] dn_slave,
  input  logic             clr_en,
  input  logic [2:0]       clr_mask,
  output logic [2:0]       status,
  output logic             err_pulse
);

  localparam int ENT_W = SLV_W + 2;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [ENT_W-1:0] head;
  logic             empty, pop, push;
  logic [2:0]       mism;

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign pop   = dn_valid && !empty;
  assign push  = req_valid && ((count != FULL) || pop);

  assign mism[0] = pop && (head[ENT_W-1] != dn_write);
  assign mism[1] = pop && (head[ENT_W-2] != dn_burst);
  assign mism[2] = dn_valid && (empty || (head[SLV_W-1:0] != dn_slave));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {req_write, req_burst, req_slave};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= '0;
      err_pulse <= 1'b0;
    end else begin
      status    <= (status & ~(clr_en ? clr_mask : 3'b000)) | mism;
      err_pulse <= |mism;
    end
  end

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  // R4
  orphan_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && empty) |=> (err_pulse && status[2]));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((status & $past(status)) == $past(status)));

  // R8
  clear_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !dn_valid) |=> ((status & $past(clr_mask)) == 3'b000));

  // R10
  quiet_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_valid |=> !err_pulse);

  // R9
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (status != 3'b000));

  // R11
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_valid && !req_valid) |=> $stable(count));

endmodule

// File: tb/xact_integrity_chk_tb.sv
`timescale 1ns/1ps
module xact_integrity_chk_tb;
  localparam int SLV_W = 2;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_burst = 0;
  logic [SLV_W-1:0] req_slave = '0;
  logic dn_valid = 0, dn_write = 0, dn_burst = 0;
  logic [SLV_W-1:0] dn_slave = '0;
  logic clr_en = 0;
  logic [2:0] clr_mask = '0;
  logic [2:0] status;
  logic err_pulse;

  int checks = 0;
  int errors = 0;

  logic [SLV_W+1:0] model_q[$];
  logic [3:0]       res_q[$];
  string            tag_q[$];
  logic [2:0]       st_m = '0;
  bit               done = 0;

  always #2 clk = ~clk;

  xact_integrity_chk #(.SLV_W(SLV_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst), .req_slave(req_slave),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_burst(dn_burst), .dn_slave(dn_slave),
    .clr_en(clr_en), .clr_mask(clr_mask), .status(status), .err_pulse(err_pulse)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {err,status} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic rw, input logic rb, input logic [SLV_W-1:0] rs,
                      input logic dv, input logic dw, input logic db, input logic [SLV_W-1:0] ds,
                      input logic ce, input logic [2:0] cm, input string tag);
    logic [2:0] mm;
    logic [SLV_W+1:0] hd;
    bit was_empty, popped;
    @(negedge clk);
    req_valid = rv; req_write = rw; req_burst = rb; req_slave = rs;
    dn_valid = dv;  dn_write = dw;  dn_burst = db;  dn_slave = ds;
    clr_en = ce; clr_mask = cm;
    @(posedge clk);
    mm = 3'b000;
    was_empty = (model_q.size() == 0);
    popped = dv && !was_empty;
    if (dv && was_empty) mm[2] = 1'b1;
    if (popped) begin
      hd = model_q.pop_front();
      mm[0] = (hd[SLV_W+1] != dw);
      mm[1] = (hd[SLV_W] != db);
      mm[2] = (hd[SLV_W-1:0] != ds);
    end
    if (rv && ((was_empty ? 0 : model_q.size() + (popped ? 1 : 0)) < DEPTH || popped))
      model_q.push_back({rw, rb, rs});
    st_m = (st_m & ~(ce ? cm : 3'b000)) | mm;
    res_q.push_back({|mm, st_m});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, '0, 0, 0, 0, '0, 0, 3'b000, tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (res_q.size() != 0) check(tag_q.pop_front(), {err_pulse, status}, res_q.pop_front());
    end
  end

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1 reset", {err_pulse, status}, 4'b0000);
    rst_n = 1'b1;
    idle("R1 idle after reset");

    // R5 matching read single to slave 2
    step(1, 0, 0, 2'd2, 0, 0, 0, '0, 0, 3'b000, "R5 issue");
    step(0, 0, 0, '0, 1, 0, 0, 2'd2, 0, 3'b000, "R5 match");
    // R2 direction
    step(1, 0, 1, 2'd1, 0, 0, 0, '0, 0, 3'b000, "R2 issue");
    step(0, 0, 0, '0, 1, 1, 1, 2'd1, 0, 3'b000, "R2 dir mismatch");
    idle("R10 pulse ends");
    // R8 clear bit 0 only
    step(0, 0, 0, '0, 0, 0, 0, '0, 1, 3'b001, "R8 clear dir");
    // R3 burst
    step(1, 1, 1, 2'd3, 0, 0, 0, '0, 0, 3'b000, "R3 issue");
    step(0, 0, 0, '0, 1, 1, 0, 2'd3, 0, 3'b000, "R3 burst mismatch");
    // R4 destination and orphan
    step(1, 1, 0, 2'd0, 0, 0, 0, '0, 0, 3'b000, "R4 issue");
    step(0, 0, 0, '0, 1, 1, 0, 2'd1, 0, 3'b000, "R4 dest mismatch");
    step(0, 0, 0, '0, 0, 0, 0, '0, 1, 3'b111, "R8 clear all");
    step(0, 0, 0, '0, 1, 1, 1, 2'd0, 0, 3'b000, "R4 orphan only dest");
    step(0, 0, 0, '0, 0, 0, 0, '0, 1, 3'b100, "R8 clear dest");
    // R6/R7 fill, overflow, drain in order
    for (int i = 0; i < DEPTH; i++)
      step(1, i[0], i[1], SLV_W'(i), 0, 0, 0, '0, 0, 3'b000, "R6 fill");
    step(1, 1, 1, 2'd3, 0, 0, 0, '0, 0, 3'b000, "R7 discard when full");
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 0, '0, 1, i[0], i[1], SLV_W'(i), 0, 3'b000, "R6 in-order match");
    step(0, 0, 0, '0, 1, 1, 1, 2'd3, 0, 3'b000, "R7 discarded request absent");
    // R9 set wins over clear; R10 repeat pulse
    step(0, 0, 0, '0, 1, 0, 0, 2'd0, 1, 3'b100, "R9 set beats clear");
    step(0, 0, 0, '0, 1, 0, 0, 2'd0, 0, 3'b000, "R10 repeat pulse");
    step(0, 0, 0, '0, 0, 0, 0, '0, 1, 3'b111, "R8 clear all again");
    // R11 simultaneous push and pop on empty
    step(1, 0, 1, 2'd2, 1, 0, 1, 2'd2, 0, 3'b000, "R11 same-cycle not compared");
    step(0, 0, 0, '0, 1, 0, 1, 2'd2, 0, 3'b000, "R11 queued entry matches");
    step(0, 0, 0, '0, 0, 0, 0, '0, 1, 3'b100, "R8 clear dest");
    // R7 full with pop and push together keeps the push
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, 0, SLV_W'(i), 0, 0, 0, '0, 0, 3'b000, "R7 refill");
    step(1, 1, 1, 2'd1, 1, 0, 0, 2'd0, 0, 3'b000, "R7 push with pop on full");
    for (int i = 1; i < DEPTH; i++)
      step(0, 0, 0, '0, 1, 0, 0, SLV_W'(i), 0, 3'b000, "R6 drain");
    step(0, 0, 0, '0, 1, 1, 1, 2'd1, 0, 3'b000, "R7 kept entry matches");
    // R12 all three differ
    step(1, 0, 0, 2'd0, 0, 0, 0, '0, 0, 3'b000, "R12 issue");
    step(0, 0, 0, '0, 1, 1, 1, 2'd3, 0, 3'b000, "R12 triple mismatch");
    step(0, 0, 0, '0, 0, 0, 0, '0, 1, 3'b010, "R8 partial clear");
    idle("R10 idle");
    idle("R10 idle");
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule